// File: doc/BRIEF.md
# Serial Port Byte Buffer Window

This block holds the receive and transmit byte queues of a serial port and presents them to a 32-bit register bus as two memory windows. Software does not move data one byte per access. On receive, it reads a word range of the receive window, where the lanes are the oldest unread bytes in little-endian order. It then writes how many bytes it consumed to a release word. On transmit, it stores bytes into the transmit window at offsets counted from the current write pointer, using byte enables. It then writes how many bytes it added to a commit word, and only then do those bytes become visible to the line side.

The line side is a plain byte interface. The receive shifter pushes one byte per cycle. The transmit shifter sees the oldest committed byte and pops it.

Two level flags compare the fill state with thresholds chosen by 3-bit trigger codes. An interrupt aggregator outside this block can use them.

Top module: `serial_fifo_window`

## Requirements
- R1: After reset both queues are empty, all pointers are zero, the transmit trigger code is 5 and the receive trigger code is 6, `rx_level_flag` is 0 and `tx_space_flag` is 1.
- R2: A cycle with `rx_push` high appends `rx_byte` to the receive queue. The status word at byte offset 0x000 reports the 10-bit receive fill count as follows:
  - count bits 7:0 in status bits 31:24
  - count bits 9:8 in status bits 7:6
  - `rx_level_flag` in status bit 0
  - `tx_space_flag` in status bit 1
  - zeros elsewhere
- R3: A read at byte offset 0x004+4m returns the unread bytes 4m..4m+3, counted from the oldest, with byte 4m in bits 7:0. Indices wrap modulo 1024, so the last reachable word, at 0x3FC, holds bytes 1016..1019. Window reads change no count or pointer.
- R4: Writing N to bits 9:0 of the release word at 0x800 removes min(N, fill count) bytes from the head of the receive queue.
- R5: Each queue holds at most 1023 bytes. A push into a receive queue holding 1023 bytes is dropped.
- R6: A write at byte offset 0x400+j stores each enabled byte lane i at transmit position (write pointer + j + i) mod 1024. It changes neither the transmit count nor the write pointer.
- R7: Writing N to bits 9:0 of the commit word at 0x804 adds min(N, 1023 − transmit count) bytes and advances the write pointer by the same amount. A read of 0x804 returns the write pointer in bits 9:0 and the transmit count in bits 25:16.
- R8: `tx_valid` is high whenever the transmit count is non-zero. `tx_byte` is the oldest committed byte, and `tx_pop` while valid consumes it.
- R9: The config word at 0x808 holds the transmit trigger code in bits 18:16 and the receive trigger code in bits 22:20. Code n selects a threshold of 2^(n+2) bytes.
- R10: `rx_level_flag` is high when the receive count is at least the receive threshold. `tx_space_flag` is high when 1023 minus the transmit count is at least the transmit threshold.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd`. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables for transmit window writes |
| bus_rdata | output | 32 | Registered read data |
| rx_push | input | 1 | Receive byte strobe from the shifter |
| rx_byte | input | 8 | Received byte |
| tx_pop | input | 1 | Transmit byte consumed by the shifter |
| tx_byte | output | 8 | Oldest committed transmit byte |
| tx_valid | output | 1 | Transmit queue not empty |
| rx_level_flag | output | 1 | Receive fill at or above threshold |
| tx_space_flag | output | 1 | Transmit free space at or above threshold |

## Verification
A wrong pointer shows up at once as wrong window contents. After the first push or release that exposes it, a window read, or `tx_byte`, carries a byte from the wrong slot, and every later access stays shifted by the same offset. A wrong count shows up in the status or commit-word read on the very next access, and within one cycle as a flag that disagrees with the threshold table. A missing clamp makes the count wrap past 1023, which a single read of the count field exposes.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  localparam logic [11:0] ADDR_STATUS  = 12'h000;
  localparam logic [11:0] ADDR_RELEASE = 12'h800;
  localparam logic [11:0] ADDR_COMMIT  = 12'h804;
  localparam logic [11:0] ADDR_CONFIG  = 12'h808;
  localparam logic [2:0]  TX_CODE_RST  = 3'd5;
  localparam logic [2:0]  RX_CODE_RST  = 3'd6;

  // Threshold in bytes for a 3-bit trigger code: 2^(code+2)
  function automatic logic [10:0] level_bytes(input logic [2:0] code);
    return 11'd4 << code;
  endfunction

  // Requested amount limited to what is available
  function automatic logic [9:0] clamp10(input logic [9:0] req, input logic [9:0] lim);
    return (req > lim) ? lim : req;
  endfunction

  // Status word: split receive count plus the two flags
  function automatic logic [31:0] pack_status(input logic [9:0] rxc, input logic rxf,
                                              input logic txf);
    return {rxc[7:0], 16'h0000, rxc[9:8], 4'b0000, txf, rxf};
  endfunction
endpackage

// File: rtl/sfw_rx_buf.sv
module sfw_rx_buf
  import sfw_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    push_byte,
  input  logic          rel_en,
  input  logic [AW-1:0] rel_n,
  input  logic [AW-1:0] win_idx,
  output logic [31:0]   win_word,
  output logic [AW-1:0] count,
  output logic [AW-1:0] rptr
);
  localparam logic [AW-1:0] FULL = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr;
  logic          accept;
  logic [AW-1:0] rel_amt;

  assign accept  = push && (count != FULL);
  assign rel_amt = rel_en ? AW'(clamp10(10'(rel_n), 10'(count))) : '0;

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= push_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (accept) wptr <= wptr + 1'b1;
      rptr  <= rptr + rel_amt;
      count <= count + AW'(accept) - rel_amt;
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign win_word[8*i +: 8] = mem[rptr + win_idx + AW'(i)];
  end

  p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && count == FULL && !rel_en) |=> (count == FULL));
  p_release_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && !push && rel_n >= count) |=> (count == '0));
endmodule

// File: rtl/sfw_tx_buf.sv
module sfw_tx_buf
  import sfw_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [31:0]   wr_data,
  input  logic [3:0]    wr_be,
  input  logic          commit_en,
  input  logic [AW-1:0] commit_n,
  input  logic          pop,
  output logic [7:0]    tx_byte,
  output logic          tx_valid,
  output logic [AW-1:0] count,
  output logic [AW-1:0] wptr
);
  localparam logic [AW-1:0] FULL = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rdptr;
  logic [AW-1:0] free_sp;
  logic [AW-1:0] commit_amt;
  logic          pop_ok;

  assign free_sp    = FULL - count;
  assign commit_amt = commit_en ? AW'(clamp10(10'(commit_n), 10'(free_sp))) : '0;
  assign pop_ok     = pop && (count != '0);
  assign tx_valid   = (count != '0);
  assign tx_byte    = mem[rdptr];

  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (wr_en && wr_be[i]) mem[wptr + wr_idx + AW'(i)] <= wr_data[8*i +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rdptr <= '0;
      count <= '0;
    end else begin
      wptr <= wptr + commit_amt;
      if (pop_ok) rdptr <= rdptr + 1'b1;
      count <= count + commit_amt - AW'(pop_ok);
    end
  end

  p_commit_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_en && !pop && commit_n >= (FULL - count)) |=> (count == FULL));
  p_pop_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count != '0 && !commit_en) |=> (count == $past(count) - 1'b1));
  p_write_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !commit_en && !pop) |=> (count == $past(count) && $stable(wptr)));
endmodule

// File: rtl/serial_fifo_window.sv
module serial_fifo_window
  import sfw_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  input  logic [3:0]  bus_be,
  output logic [31:0] bus_rdata,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  output logic        tx_valid,
  output logic        rx_level_flag,
  output logic        tx_space_flag
);
  localparam logic [AW-1:0] FULL = AW'(DEPTH - 1);

  logic          hit_rx_win, hit_tx_win, hit_status, hit_rel, hit_cmt, hit_cfg, unmapped;
  logic [AW-1:0] word_off;
  logic [31:0]   rx_win_word;
  logic [AW-1:0] rx_count, rx_rptr, tx_count, tx_wptr;
  logic [2:0]    cfg_tx, cfg_rx;
  logic [31:0]   rd_next;

  assign word_off   = {bus_addr[AW-1:2], 2'b00};
  assign hit_rx_win = (bus_addr[11:10] == 2'b00) && (bus_addr[9:2] != 8'h00);
  assign hit_tx_win = (bus_addr[11:10] == 2'b01);
  assign hit_status = (bus_addr[11:2] == ADDR_STATUS[11:2]);
  assign hit_rel    = (bus_addr[11:2] == ADDR_RELEASE[11:2]);
  assign hit_cmt    = (bus_addr[11:2] == ADDR_COMMIT[11:2]);
  assign hit_cfg    = (bus_addr[11:2] == ADDR_CONFIG[11:2]);
  assign unmapped   = !(hit_rx_win || hit_tx_win || hit_status || hit_rel || hit_cmt || hit_cfg);

  sfw_rx_buf #(.DEPTH(DEPTH)) rx_i (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .push_byte(rx_byte),
    .rel_en(bus_wr && hit_rel), .rel_n(bus_wdata[AW-1:0]),
    .win_idx(word_off - AW'(4)), .win_word(rx_win_word),
    .count(rx_count), .rptr(rx_rptr)
  );

  sfw_tx_buf #(.DEPTH(DEPTH)) tx_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_wr && hit_tx_win), .wr_idx(word_off), .wr_data(bus_wdata), .wr_be(bus_be),
    .commit_en(bus_wr && hit_cmt), .commit_n(bus_wdata[AW-1:0]),
    .pop(tx_pop), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .count(tx_count), .wptr(tx_wptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_tx <= TX_CODE_RST;
      cfg_rx <= RX_CODE_RST;
    end else if (bus_wr && hit_cfg) begin
      cfg_tx <= bus_wdata[18:16];
      cfg_rx <= bus_wdata[22:20];
    end
  end

  assign rx_level_flag = {1'b0, 10'(rx_count)} >= level_bytes(cfg_rx);
  assign tx_space_flag = {1'b0, 10'(FULL - tx_count)} >= level_bytes(cfg_tx);

  always_comb begin
    rd_next = '0;
    if (hit_status)      rd_next = pack_status(10'(rx_count), rx_level_flag, tx_space_flag);
    else if (hit_rx_win) rd_next = rx_win_word;
    else if (hit_rel)    rd_next = {22'h0, 10'(rx_rptr)};
    else if (hit_cmt)    rd_next = {6'h0, 10'(tx_count), 6'h0, 10'(tx_wptr)};
    else if (hit_cfg)    rd_next = {9'h0, cfg_rx, 1'b0, cfg_tx, 16'h0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && unmapped) |=> (bus_rdata == 32'h0));
  p_win_read_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && hit_rx_win && !rx_push) |=> $stable(rx_count));
endmodule

// File: tb/serial_fifo_window_tb_top.sv
module serial_fifo_window_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_pop = 1'b0;
  logic [7:0]  tx_byte;
  logic        tx_valid, rx_level_flag, tx_space_flag;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  serial_fifo_window dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .rx_push(rx_push), .rx_byte(rx_byte), .tx_pop(tx_pop), .tx_byte(tx_byte),
    .tx_valid(tx_valid), .rx_level_flag(rx_level_flag), .tx_space_flag(tx_space_flag)
  );

  // {rx trigger code, expected rx_level_flag} with 100 bytes queued
  localparam logic [3:0] LVL_VEC [8] = '{
    {3'd0, 1'b1}, {3'd1, 1'b1}, {3'd2, 1'b1}, {3'd3, 1'b1},
    {3'd4, 1'b1}, {3'd5, 1'b0}, {3'd6, 1'b0}, {3'd7, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] pat_a(input int i);
    return 8'(i * 7 + 3);
  endfunction

  function automatic logic [7:0] pat_b(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    bus_read(12'h000, rd); check("R1 status after reset", rd, 32'h0000_0002);
    bus_read(12'h808, rd); check("R1 R9 config reset codes", rd, 32'h0065_0000);
    bus_read(12'h804, rd); check("R1 tx control after reset", rd, 32'h0);
    check("R1 tx_valid low", {31'h0, tx_valid}, 32'h0);
    check("R1 tx_space_flag high", {31'h0, tx_space_flag}, 32'h1);

    // R2: push 100 bytes, status reports the count
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); rx_push = 1'b1; rx_byte = pat_a(i);
    end
    @(negedge clk); rx_push = 1'b0;
    bus_read(12'h000, rd); check("R2 status with 100 bytes", rd, 32'h6400_0002);

    // R3: window reads, twice to show no side effect
    bus_read(12'h004, rd);
    check("R3 window word 0", rd, {pat_a(3), pat_a(2), pat_a(1), pat_a(0)});
    bus_read(12'h02C, rd);
    check("R3 window word 10", rd, {pat_a(43), pat_a(42), pat_a(41), pat_a(40)});
    bus_read(12'h004, rd);
    check("R3 window reread", rd, {pat_a(3), pat_a(2), pat_a(1), pat_a(0)});
    bus_read(12'h000, rd); check("R3 count unchanged by reads", rd, 32'h6400_0002);

    // R9 R10: trigger code table walk
    for (int v = 0; v < 8; v++) begin
      bus_write(12'h808, {9'h0, LVL_VEC[v][3:1], 1'b0, 3'd5, 16'h0}, 4'hF);
      check($sformatf("R10 rx flag code %0d", LVL_VEC[v][3:1]),
            {31'h0, rx_level_flag}, {31'h0, LVL_VEC[v][0]});
    end
    bus_write(12'h808, 32'h0065_0000, 4'hF);

    // R4: release 10, window moves
    bus_write(12'h800, 32'd10, 4'hF);
    bus_read(12'h000, rd); check("R4 status after release 10", rd, 32'h5A00_0002);
    bus_read(12'h004, rd);
    check("R4 window after release", rd, {pat_a(13), pat_a(12), pat_a(11), pat_a(10)});
    // R4: oversized release is clamped
    bus_write(12'h800, 32'd500, 4'hF);
    bus_read(12'h000, rd); check("R4 clamped release empties", rd, 32'h0000_0002);
    bus_read(12'h800, rd); check("R4 read pointer", rd, 32'd100);

    // R5: overfill; extra pushes dropped
    for (int i = 0; i < 1030; i++) begin
      @(negedge clk); rx_push = 1'b1; rx_byte = pat_b(i);
    end
    @(negedge clk); rx_push = 1'b0;
    bus_read(12'h000, rd); check("R5 R2 status full", rd, 32'hFF00_00C3);
    bus_read(12'h004, rd);
    check("R3 window head after wrap", rd, {pat_b(3), pat_b(2), pat_b(1), pat_b(0)});
    bus_read(12'h3FC, rd);
    check("R3 last window word", rd, {pat_b(1019), pat_b(1018), pat_b(1017), pat_b(1016)});
    bus_write(12'h800, 32'd1023, 4'hF);
    bus_read(12'h000, rd); check("R4 full release", rd, 32'h0000_0002);

    // R6: window writes are invisible until commit
    bus_write(12'h400, 32'h4433_2211, 4'hF);
    bus_write(12'h404, 32'hAAAA_6655, 4'h3);
    bus_read(12'h804, rd); check("R6 no commit yet", rd, 32'h0);
    check("R6 tx_valid still low", {31'h0, tx_valid}, 32'h0);

    // R7: commit
    bus_write(12'h804, 32'd6, 4'hF);
    bus_read(12'h804, rd); check("R7 pointer and count", rd, 32'h0006_0006);

    // R8: line-side pops
    begin
      logic [7:0] exp_b [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        check("R8 tx_valid", {31'h0, tx_valid}, 32'h1);
        check($sformatf("R8 tx byte %0d", i), {24'h0, tx_byte}, {24'h0, exp_b[i]});
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
      end
    end
    check("R8 drained", {31'h0, tx_valid}, 32'h0);
    bus_read(12'h804, rd); check("R7 after drain", rd, 32'h0000_0006);

    // R7: clamp at full
    bus_write(12'h804, 32'd1023, 4'hF);
    bus_read(12'h804, rd); check("R7 full commit", rd, 32'h03FF_0005);
    check("R10 tx flag low when full", {31'h0, tx_space_flag}, 32'h0);
    bus_write(12'h804, 32'd5, 4'hF);
    bus_read(12'h804, rd); check("R7 commit clamped", rd, 32'h03FF_0005);

    @(negedge clk); tx_pop = 1'b1;
    repeat (1023) @(negedge clk);
    tx_pop = 1'b0;
    bus_read(12'h804, rd); check("R8 full drain", rd, 32'h0000_0005);
    check("R10 tx flag back high", {31'h0, tx_space_flag}, 32'h1);

    // R11: unmapped read
    bus_read(12'h900, rd); check("R11 unmapped read zero", rd, 32'h0);

    finish_run();
  end
endmodule